// File: doc/BRIEF.md
# Serial Channel Interrupt Aggregator

The block turns the event lines of one serial channel into two processor interrupt requests, one for transmit and one for receive. Each event pulse from the transmitter or receiver sets a sticky status bit. Each status bit has its own enable bit. The enabled, active bits are ORed into a transmit summary flag and a receive summary flag. A flag becomes a request only when the matching top-level enable bit is also set. The request passes through one register stage.

The host reaches the status and enable registers through a small synchronous register port. A write of 1 to a status bit clears that bit. The enable registers are plain read/write registers. A read-only summary register returns both flags. Register map: 0 `line_stat`, 1 `rx_stat`, 2 `frm_stat`, 3 `line_en`, 4 `rx_en`, 5 `frm_en`, 6 `top_en`, 7 `summary`. Read data is combinational from `addr_i`. All registers reset to 0.

Top module: `scc_irq_agg`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit, and the bit stays set until the host writes 1 to that bit position. Writing 0 to a status bit leaves it unchanged. `line_evt_i[k]` maps to `line_stat` bit k, `rx_evt_i[k]` maps to `rx_stat` bit k+2, and `frame_evt_i` maps to `frm_stat` bit 7.
- R2: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends set.
- R3: The transmit flag is 1 exactly when at least one of `line_stat` bits 7, 6 and 3 is set together with the same bit of `line_en`.
- R4: The receive flag is 1 exactly when any of the following is true:
  - one of `line_stat` bits 5, 4, 2, 1 or 0 is set and the same bit of `line_en` is set;
  - one of `rx_stat` bits 7..2 is set and the same bit of `rx_en` is set;
  - `frm_stat` bit 7 and `frm_en` bit 7 are both set.
- R5: `summary` (address 7) reads the transmit flag in bit 0 and the receive flag in bit 1, with all other bits 0. A write to this address changes no register and no output.
- R6: A change to an enable bit changes the summary flag in the same cycle that the enable register updates. It leaves every status bit unchanged, so an event that was masked raises its flag as soon as it is enabled.
- R7: `tx_req_o` is 1 in the cycle after the transmit flag and `top_en` bit 0 are both 1, and 0 otherwise. `rx_req_o` behaves the same way with the receive flag and `top_en` bit 1.
- R8: After reset, every register reads 0 and both requests are 0.
- R9: The following bits always read 0 and ignore writes:
  - `rx_stat` and `rx_en` bits 1..0;
  - `frm_stat` and `frm_en` bits 6..0;
  - `top_en` bits 7..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| line_evt_i | input | 8 | Line event pulses, sets `line_stat` |
| rx_evt_i | input | 6 | Receive event pulses, sets `rx_stat` bits 7..2 |
| frame_evt_i | input | 1 | End-of-frame event pulse, sets `frm_stat` bit 7 |
| tx_req_o | output | 1 | Transmit interrupt request |
| rx_req_o | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is a set and a clear landing on the same status bit in one cycle. Close behind it is an event that arrives while masked and is enabled only later.

Directed steps create both cases. A directed step pulses an event in the same cycle as a write-1 clear to that bit. Other steps set events with every enable off and then turn enables on one register at a time. A long random phase follows with sparse event pulses and random writes to every address, including the summary address and the reserved bits. Each step is compared against a bench model of all registers and of the registered requests.

// File: rtl/scc_irq_pkg.sv
package scc_irq_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int RXW = 6;   // rx_stat implemented bits 7..2
  localparam int RXLSB = DW - RXW;

  localparam logic [AW-1:0] A_LINE_STAT = 3'd0;
  localparam logic [AW-1:0] A_RX_STAT   = 3'd1;
  localparam logic [AW-1:0] A_FRM_STAT  = 3'd2;
  localparam logic [AW-1:0] A_LINE_EN   = 3'd3;
  localparam logic [AW-1:0] A_RX_EN     = 3'd4;
  localparam logic [AW-1:0] A_FRM_EN    = 3'd5;
  localparam logic [AW-1:0] A_TOP_EN    = 3'd6;
  localparam logic [AW-1:0] A_SUMMARY   = 3'd7;

  // line_stat bit split between transmit and receive summaries
  localparam logic [DW-1:0] TX_LINE_MASK = 8'hC8;
  localparam logic [DW-1:0] RX_LINE_MASK = 8'h37;
endpackage

// File: rtl/sticky_w1c.sv
module sticky_w1c #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;  // set beats clear
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end

  // R1
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(q_o) & ~$past(clr_i) & ~q_o) == '0));
  // R1
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q_o & $past(clr_i) & ~$past(set_i)) == '0));
  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/mask_or.sv
module mask_or #(
  parameter int W = 8
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  output logic         any_o
);
  assign any_o = |(stat_i & en_i);
endmodule

// File: rtl/scc_irq_agg.sv
module scc_irq_agg
  import scc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     line_evt_i,
  input  logic [RXW-1:0]    rx_evt_i,
  input  logic              frame_evt_i,
  output logic              tx_req_o,
  output logic              rx_req_o
);
  logic [DW-1:0]  line_stat, line_en;
  logic [RXW-1:0] rx_stat, rx_en;
  logic           frm_stat, frm_en;
  logic [1:0]     top_en;
  logic           tx_flag, rx_flag;
  logic           rx_line_any, rx_stat_any;

  logic wr_line_stat, wr_rx_stat, wr_frm_stat;
  assign wr_line_stat = wr_en_i && (addr_i == A_LINE_STAT);
  assign wr_rx_stat   = wr_en_i && (addr_i == A_RX_STAT);
  assign wr_frm_stat  = wr_en_i && (addr_i == A_FRM_STAT);

  sticky_w1c #(.W(DW)) u_line_stat (
    .clk_i, .rst_ni,
    .set_i (line_evt_i),
    .clr_i (wr_line_stat ? wdata_i : '0),
    .q_o   (line_stat)
  );

  sticky_w1c #(.W(RXW)) u_rx_stat (
    .clk_i, .rst_ni,
    .set_i (rx_evt_i),
    .clr_i (wr_rx_stat ? wdata_i[DW-1:RXLSB] : '0),
    .q_o   (rx_stat)
  );

  sticky_w1c #(.W(1)) u_frm_stat (
    .clk_i, .rst_ni,
    .set_i (frame_evt_i),
    .clr_i (wr_frm_stat & wdata_i[DW-1]),
    .q_o   (frm_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_en <= '0;
      rx_en   <= '0;
      frm_en  <= 1'b0;
      top_en  <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_LINE_EN: line_en <= wdata_i;
        A_RX_EN:   rx_en   <= wdata_i[DW-1:RXLSB];
        A_FRM_EN:  frm_en  <= wdata_i[DW-1];
        A_TOP_EN:  top_en  <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  mask_or #(.W(DW)) u_tx_or (
    .stat_i (line_stat & TX_LINE_MASK), .en_i (line_en), .any_o (tx_flag));
  mask_or #(.W(DW)) u_rx_line_or (
    .stat_i (line_stat & RX_LINE_MASK), .en_i (line_en), .any_o (rx_line_any));
  mask_or #(.W(RXW)) u_rx_stat_or (
    .stat_i (rx_stat), .en_i (rx_en), .any_o (rx_stat_any));

  assign rx_flag = rx_line_any | rx_stat_any | (frm_stat & frm_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_req_o <= 1'b0;
      rx_req_o <= 1'b0;
    end else begin
      tx_req_o <= tx_flag & top_en[0];
      rx_req_o <= rx_flag & top_en[1];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LINE_STAT: rdata_o = line_stat;
      A_RX_STAT:   rdata_o[DW-1:RXLSB] = rx_stat;
      A_FRM_STAT:  rdata_o[DW-1] = frm_stat;
      A_LINE_EN:   rdata_o = line_en;
      A_RX_EN:     rdata_o[DW-1:RXLSB] = rx_en;
      A_FRM_EN:    rdata_o[DW-1] = frm_en;
      A_TOP_EN:    rdata_o[1:0] = top_en;
      A_SUMMARY:   rdata_o[1:0] = {rx_flag, tx_flag};
      default: ;
    endcase
  end

  // R7
  tx_req_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flag && top_en[0]) |=> tx_req_o);
  // R7
  tx_req_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_flag && top_en[0]) |=> !tx_req_o);
  // R7
  rx_req_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_flag && top_en[1]) |=> !rx_req_o);
  // R6
  en_keeps_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_LINE_EN && line_evt_i == '0) |=> $stable(line_stat));
  // R3
  tx_flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flag |-> (line_stat[7] || line_stat[6] || line_stat[3]));
endmodule

// File: tb/tb_scc_irq_agg.sv
module tb_scc_irq_agg;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] line_evt = '0;
  logic [5:0] rx_evt = '0;
  logic       frame_evt = 1'b0;
  logic       tx_req, rx_req;

  int n_tests = 0;
  int n_fail = 0;

  // model state
  logic [7:0] m_ls, m_rs, m_fs, m_le, m_re, m_fe, m_te;
  logic       m_txr, m_rxr;

  always #(PERIOD/2) clk = ~clk;

  scc_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .line_evt_i(line_evt),
    .rx_evt_i(rx_evt), .frame_evt_i(frame_evt),
    .tx_req_o(tx_req), .rx_req_o(rx_req));

  function automatic logic f_tx();
    return |(m_ls & m_le & 8'hC8);
  endfunction

  function automatic logic f_rx();
    return |(m_ls & m_le & 8'h37) | |(m_rs & m_re) | |(m_fs & m_fe);
  endfunction

  function automatic logic [7:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ls;
      3'd1: return m_rs;
      3'd2: return m_fs;
      3'd3: return m_le;
      3'd4: return m_re;
      3'd5: return m_fe;
      3'd6: return m_te;
      default: return {6'b0, f_rx(), f_tx()};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic w, input logic [2:0] a,
                      input logic [7:0] d, input logic [7:0] le,
                      input logic [5:0] re, input logic fe);
    logic [7:0] clr;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; line_evt = le; rx_evt = re; frame_evt = fe;
    m_txr = f_tx() & m_te[0];
    m_rxr = f_rx() & m_te[1];
    clr = w ? d : 8'h00;
    if (a == 3'd0) m_ls = (m_ls & ~clr) | le;                else m_ls = m_ls | le;
    if (a == 3'd1) m_rs = ((m_rs & ~clr) | {re, 2'b0}) & 8'hFC; else m_rs = m_rs | {re, 2'b0};
    if (a == 3'd2) m_fs = ((m_fs & ~clr) | {fe, 7'b0}) & 8'h80; else m_fs = m_fs | {fe, 7'b0};
    if (w) begin
      case (a)
        3'd3: m_le = d;
        3'd4: m_re = d & 8'hFC;
        3'd5: m_fe = d & 8'h80;
        3'd6: m_te = d & 8'h03;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    chk({tag, " rdata"}, rdata, f_read(a));
    chk({tag, " tx_req"}, {7'b0, tx_req}, {7'b0, m_txr});
    chk({tag, " rx_req"}, {7'b0, rx_req}, {7'b0, m_rxr});
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 1'b0, a, 8'h00, 8'h00, 6'h00, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 1'b1, a, d, 8'h00, 6'h00, 1'b0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_ls = 0; m_rs = 0; m_fs = 0; m_le = 0; m_re = 0; m_fe = 0; m_te = 0;
    m_txr = 0; m_rxr = 0;
    void'($urandom(32'h5CA1_0001));
    #(PERIOD * 3);
    @(negedge clk) rst_ni = 1'b1;

    // R8 reset state
    for (int a = 0; a < 8; a++) rd("R8 reset", a[2:0]);

    // R1 set, hold, write-0 no effect, write-1 clear
    step("R1 set", 1'b0, 3'd0, 8'h00, 8'h81, 6'h21, 1'b1);
    rd("R1 hold", 3'd0);
    wr("R1 write0", 3'd0, 8'h7E);
    rd("R1 after write0", 3'd0);
    wr("R1 clear", 3'd0, 8'h01);
    rd("R1 rx_stat", 3'd1);
    rd("R1 frm_stat", 3'd2);

    // R2 set and clear same bit same cycle
    step("R2 set_wins", 1'b1, 3'd0, 8'h80, 8'h80, 6'h00, 1'b0);
    rd("R2 readback", 3'd0);

    // R6 masked events then enable
    wr("R6 top_en", 3'd6, 8'hFF);
    rd("R9 top_en reserved", 3'd6);
    rd("R6 masked summary", 3'd7);
    wr("R6 en tx", 3'd3, 8'h80);
    rd("R6 summary tx", 3'd7);
    rd("R7 tx_req lag", 3'd0);
    wr("R6 disable", 3'd3, 8'h00);
    rd("R6 status kept", 3'd0);

    // R3 only tx bits matter
    wr("R3 clear all", 3'd0, 8'hFF);
    step("R3 bit3", 1'b0, 3'd7, 8'h00, 8'h08, 6'h00, 1'b0);
    wr("R3 en other", 3'd3, 8'h37);
    rd("R3 not tx", 3'd7);
    wr("R3 en bit3", 3'd3, 8'h08);
    rd("R3 tx on", 3'd7);

    // R4 each rx source
    wr("R4 clr line", 3'd0, 8'hFF);
    wr("R4 en off", 3'd3, 8'h00);
    wr("R4 rx_en", 3'd4, 8'hFF);
    rd("R9 rx_en reserved", 3'd4);
    rd("R4 rx pending", 3'd7);
    wr("R4 frm_en", 3'd5, 8'hFF);
    rd("R9 frm_en reserved", 3'd5);
    wr("R4 clr rx", 3'd1, 8'hFF);
    rd("R4 frame only", 3'd7);
    wr("R4 clr frm", 3'd2, 8'hFF);
    rd("R4 all clear", 3'd7);
    step("R4 line bit0", 1'b0, 3'd7, 8'h00, 8'h01, 6'h00, 1'b0);
    wr("R4 en bit0", 3'd3, 8'h01);
    rd("R7 rx_req", 3'd7);

    // R5 summary write ignored
    wr("R5 write summary", 3'd7, 8'hFF);
    for (int a = 0; a < 8; a++) rd("R5 after write", a[2:0]);

    // R9 reserved status bits
    wr("R9 rx_stat low", 3'd1, 8'h03);
    rd("R9 rx_stat", 3'd1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] le;
      logic [5:0] re;
      logic fe;
      logic w;
      le = 8'($urandom & $urandom & $urandom);
      re = 6'($urandom & $urandom & $urandom);
      fe = ($urandom % 8) == 0;
      w  = ($urandom % 3) == 0;
      step("R1/R3/R4/R7 random", w, 3'($urandom), 8'($urandom), le, re, fe);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule